// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a register of parameterizable width (four bits by default) whose behaviour on each rising clock edge is chosen by a two-bit mode code. It can keep its contents, move them one place toward bit 0 or toward the top bit, or take a whole new word from a parallel input in a single cycle. Each shift direction has its own serial input, which fills the bit position left empty by the shift.

Each stage picks its next value through its own four-way selection, driven by the shared mode code. A synchronous clear input zeroes every stage and overrides any mode. The whole register is visible at a parallel output in every cycle. The two end bits are also brought out as serial outputs, so that several registers can be chained by the surrounding logic.

Top module: `ushift_reg`

## Requirements
- R1: While `rst_n` is low, `q_out` is all zeros, and it stays zero until a clock edge with `rst_n` high changes it.
- R2: Mode code 2'b00 (hold) with `clr` low leaves `q_out` unchanged across the clock edge.
- R3: Mode code 2'b01 (shift toward bit 0) with `clr` low sets bit i to the former bit i+1, and sets the top bit (index WIDTH-1) to `sin_dn`. The former bit 0 is dropped.
- R4: Mode code 2'b10 (shift toward the top bit) with `clr` low sets bit i to the former bit i-1, and sets bit 0 to `sin_up`. The former top bit is dropped.
- R5: Mode code 2'b11 (load) with `clr` low copies all of `d_in` into the register on one edge.
- R6: `clr` high at a clock edge sets every bit to 0, whatever the mode code, `d_in` or serial inputs.
- R7: `bit0_out` always equals bit 0 of `q_out`, and `bitn_out` always equals bit WIDTH-1 of `q_out`, in the same cycle.
- R8: The serial input of the direction that is not selected, and `d_in` outside load mode, have no effect on the next register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| mode | input | 2 | 00 hold, 01 shift toward bit 0, 10 shift toward top bit, 11 load |
| sin_dn | input | 1 | Serial input entering the top bit when shifting toward bit 0 |
| sin_up | input | 1 | Serial input entering bit 0 when shifting toward the top bit |
| d_in | input | WIDTH | Parallel load data |
| q_out | output | WIDTH | Register contents |
| bit0_out | output | 1 | Bit 0, the bit leaving on a shift toward bit 0 |
| bitn_out | output | 1 | Top bit, the bit leaving on a shift toward the top bit |

## Verification
Every stage drives `q_out` directly, so a wrong selection in any bit appears at the parallel output on the cycle after the faulty edge. The bench compares that output with its own model after every clock. A misrouted neighbour connection, a swapped mode code or a serial input on the wrong end therefore shows up within one cycle of the first mode that uses it. A clear that loses priority to a mode shows up on the cycle after `clr` is asserted together with a load or shift carrying nonzero data.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_DN    = 2'b01,
    MODE_UP    = 2'b10,
    MODE_LOAD  = 2'b11
  } ushift_mode_e;

endpackage

// File: rtl/ushift_stage.sv
module ushift_stage
  import ushift_pkg::*;
(
  input  logic         clr,
  input  ushift_mode_e mode,
  input  logic         cur,     // present value of this stage
  input  logic         from_hi, // higher neighbour or serial-in
  input  logic         from_lo, // lower neighbour or serial-in
  input  logic         ld,      // parallel data bit
  output logic         nxt
);

  logic sel;

  always_comb begin
    unique case (mode)
      MODE_HOLD: sel = cur;
      MODE_DN:   sel = from_hi;
      MODE_UP:   sel = from_lo;
      MODE_LOAD: sel = ld;
      default:   sel = cur;
    endcase
  end

  assign nxt = clr ? 1'b0 : sel;

endmodule

// File: rtl/ushift_datapath.sv
module ushift_datapath
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clr,
  input  ushift_mode_e     mode,
  input  logic             sin_dn,
  input  logic             sin_up,
  input  logic [WIDTH-1:0] d_in,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_nxt
);

  localparam int TOP = WIDTH - 1;

  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_stage
      logic hi_src;
      logic lo_src;
      if (i == TOP) begin : g_top
        assign hi_src = sin_dn;
      end else begin : g_mid_hi
        assign hi_src = q[i+1];
      end
      if (i == 0) begin : g_bot
        assign lo_src = sin_up;
      end else begin : g_mid_lo
        assign lo_src = q[i-1];
      end
      ushift_stage u_stage (
        .clr     (clr),
        .mode    (mode),
        .cur     (q[i]),
        .from_hi (hi_src),
        .from_lo (lo_src),
        .ld      (d_in[i]),
        .nxt     (q_nxt[i])
      );
    end
  endgenerate

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic             sin_dn,
  input  logic             sin_up,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out,
  output logic             bit0_out,
  output logic             bitn_out
);

  localparam int TOP = WIDTH - 1;

  ushift_mode_e     mode_e;
  logic [WIDTH-1:0] q;
  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  assign mode_e = ushift_mode_e'(mode);

  ushift_datapath #(.WIDTH(WIDTH)) u_dp (
    .clr    (clr),
    .mode   (mode_e),
    .sin_dn (sin_dn),
    .sin_up (sin_up),
    .d_in   (d_in),
    .q      (q),
    .q_nxt  (q_nxt)
  );

  // register only toggles when clearing or in an active mode
  always_comb begin
    q_en = clr | (mode_e != MODE_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end

  assign q_out    = q;
  assign bit0_out = q[0];
  assign bitn_out = q[TOP];

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && $past(mode) == 2'b00) |-> (q_out == $past(q_out)));

  assert_shift_dn_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && $past(mode) == 2'b01) |->
      (q_out == {$past(sin_dn), $past(q_out[TOP:1])}));

  assert_shift_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && $past(mode) == 2'b10) |->
      (q_out == {$past(q_out[TOP-1:0]), $past(sin_up)}));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(clr) && $past(mode) == 2'b11) |-> (q_out == $past(d_in)));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(clr)) |-> (q_out == '0));

endmodule

// File: tb/ushift_reg_tb.sv
module ushift_reg_tb;

  localparam int W = 4;

  logic         clk;
  logic         rst_n;
  logic         clr;
  logic [1:0]   mode;
  logic         sin_dn;
  logic         sin_up;
  logic [W-1:0] d_in;
  logic [W-1:0] q_out;
  logic         bit0_out;
  logic         bitn_out;

  int checks;
  int failures;
  logic [W-1:0] model;
  bit done;

  ushift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode),
    .sin_dn(sin_dn), .sin_up(sin_up), .d_in(d_in),
    .q_out(q_out), .bit0_out(bit0_out), .bitn_out(bitn_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, logic c, logic [1:0] m,
                                            logic sd, logic su, logic [W-1:0] d);
    if (c) return '0;
    case (m)
      2'b00:   return cur;
      2'b01:   return {sd, cur[W-1:1]};
      2'b10:   return {cur[W-2:0], su};
      default: return d;
    endcase
  endfunction

  function automatic string tag_of(logic c, logic [1:0] m);
    if (c) return "R6";
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic check_edges();
    check("R7 bit0", {{(W-1){1'b0}}, bit0_out}, {{(W-1){1'b0}}, q_out[0]});
    check("R7 bitn", {{(W-1){1'b0}}, bitn_out}, {{(W-1){1'b0}}, q_out[W-1]});
  endtask

  // drive at negedge, the DUT updates at the next posedge, check at the following negedge
  task automatic step(logic c, logic [1:0] m, logic sd, logic su, logic [W-1:0] d, string tag);
    clr = c; mode = m; sin_dn = sd; sin_up = su; d_in = d;
    model = ref_next(model, c, m, sd, su, d);
    @(negedge clk);
    check(tag, q_out, model);
    check_edges();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] snap;
    void'($urandom(32'h5eed_0042));
    checks = 0; failures = 0; done = 0;
    rst_n = 1'b0; clr = 1'b0; mode = 2'b11; sin_dn = 1'b1; sin_up = 1'b1; d_in = '1;
    model = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", q_out, '0);
    rst_n = 1'b1;
    mode = 2'b00;
    @(negedge clk);
    check("R1 after release", q_out, '0);

    // R5 load, then R2 hold with changing inputs
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1010, "R5 load");
    step(1'b0, 2'b00, 1'b1, 1'b1, 4'b0101, "R2 hold");
    step(1'b0, 2'b00, 1'b0, 1'b1, 4'b1111, "R2 hold again");
    // R3 shift toward bit 0, sin_up toggled to show R8
    step(1'b0, 2'b01, 1'b1, 1'b0, 4'b0000, "R3 shift dn fill 1");
    step(1'b0, 2'b01, 1'b0, 1'b1, 4'b1111, "R8 R3 shift dn fill 0");
    // R4 shift toward top bit
    step(1'b0, 2'b10, 1'b0, 1'b1, 4'b0000, "R4 shift up fill 1");
    step(1'b0, 2'b10, 1'b1, 1'b0, 4'b1111, "R8 R4 shift up fill 0");
    // walk a one all the way through and out
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1000, "R5 load msb");
    for (int k = 0; k < W; k++) step(1'b0, 2'b01, 1'b0, 1'b0, 4'b0000, "R3 walk");
    // R6 clear overrides load and shift
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1111, "R5 load ones");
    step(1'b1, 2'b11, 1'b1, 1'b1, 4'b1111, "R6 clear over load");
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0110, "R5 reload");
    step(1'b1, 2'b10, 1'b1, 1'b1, 4'b1111, "R6 clear over shift");
    step(1'b1, 2'b00, 1'b1, 1'b1, 4'b1111, "R6 clear in hold");

    // constrained random: clear rarely
    for (int n = 0; n < 400; n++) begin
      logic c;
      logic [1:0] m;
      c = ($urandom % 16) == 0;
      m = 2'($urandom);
      step(c, m, 1'($urandom), 1'($urandom), W'($urandom), tag_of(c, m));
    end

    // asynchronous reset mid-run
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1011, "R5 load before reset");
    #1 rst_n = 1'b0;
    #0.5 snap = q_out;
    check("R1 async reset", snap, '0);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    step(1'b0, 2'b00, 1'b1, 1'b1, 4'b1111, "R1 R2 hold after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule